// File: doc/BRIEF.md
# Glitch-Free Redundant Clock Switchover Multiplexer

This block puts one of two free-running, mutually asynchronous clocks onto a single output clock. A select input names the wanted source. When it changes, the block hands the output over from the old clock to the new one in stages, so that the output never shows a shortened high or low phase. Neither input is special: either can serve as the primary source and the other as the standby.

Each input clock owns a lane. A lane passes the select request and the other lane's enable through its own two-stage synchronizer. It changes its output enable only on its own falling edge. A lane may turn on only after it has seen the other lane's enable go off. A clock that has died stuck high or stuck low can never confirm that it is off, so the new lane counts its own cycles while it waits. After a fixed timeout it forces the old lane off. The handover then still completes, in about 17 cycles of the new clock.

A bypass strap removes the handover from the path. The block then acts as a plain combinational 2:1 multiplexer that switches at once. An active-high asynchronous reset stands in for power-on reset and puts both lanes in a known state.

Top module: `clk_handover_mux`

## Requirements
- R1: With bypass low and the handover settled, a low `sel` routes `clk0` to `clk_out` and a high `sel` routes `clk1`.
- R2: During and right after reset, `clk_out` follows the clock that `sel` names, with no handover pending. The other clock is gated off from the first instant.
- R3: During a switch between two running clocks, no high or low phase of `clk_out` is shorter than half the period of the faster input clock.
- R4: The two lane enables are never both high. A lane enable rises only while that lane's clock is low.
- R5: After a change of `sel`, `clk_out` follows the newly named clock within 24 periods of that clock.
- R6: If the old clock is stuck high when `sel` changes, `clk_out` stays high for at least 8 new-clock periods. It then falls, stays low, and then follows the new clock.
- R7: If the old clock is stuck low when `sel` changes, `clk_out` stays low for at least 8 new-clock periods and then follows the new clock.
- R8: If the old lane does not confirm it is off within TIMEOUT_CYC new-clock cycles, the new lane forces it off. The old enable stays off for as long as the force is held.
- R9: With bypass high, `clk_out` equals `clk0` when `sel` is low and `clk1` when `sel` is high. It changes in the same instant that `sel` changes.
- R10: The handover behaves the same in both directions, for live switches and for a dead old clock on either input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | Input clock for source 0 |
| clk1 | input | 1 | Input clock for source 1 |
| rst | input | 1 | Active-high asynchronous reset, acts as power-on reset |
| sel | input | 1 | Source select: 0 picks clk0, 1 picks clk1 |
| bypass | input | 1 | Strap: 1 gives plain immediate multiplexing |
| clk_out | output | 1 | Output clock |

## Verification
The hardest case to reach is a handover away from a clock that has died, because only the forced release lets the new lane proceed. The bench keeps its two clock generators under its own control. It halts the selected clock right after a rising or falling edge, so the old clock sits at a known level when `sel` changes. It samples the output through the timeout window and checks the held level. It then checks that the output follows the new clock with no short phase. Both dead levels are covered, each on a different input, so both directions of the forced path are exercised.

// File: rtl/chs_pkg.sv
`timescale 1ns/100ps
package chs_pkg;

    localparam int unsigned N_LANES = 2;

    // Handover progress of one lane
    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,   // not requested
        HS_WAIT   = 2'd1,   // requested, peer not yet seen off
        HS_OWNED  = 2'd2,   // peer confirmed off by handshake
        HS_FORCED = 2'd3    // peer released by timeout
    } hs_state_e;

    // Synchronized view a lane has of the outside world
    typedef struct packed {
        logic req;
        logic peer_off;
    } lane_sync_t;

    function automatic logic sel_hits(input logic s, input int unsigned idx);
        return (idx == 1) ? s : ~s;
    endfunction

    function automatic hs_state_e boot_state(input logic own);
        return own ? HS_OWNED : HS_IDLE;
    endfunction

endpackage

// File: rtl/chs_sync2.sv
`timescale 1ns/100ps
module chs_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            stage1 <= load;
            q      <= load;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/chs_lane.sv
`timescale 1ns/100ps
module chs_lane
    import chs_pkg::*;
#(
    parameter int unsigned IDX         = 0,
    parameter int unsigned TIMEOUT_CYC = 12
) (
    input  logic lane_clk,
    input  logic rst,
    input  logic sel,
    input  logic peer_en,
    input  logic peer_kill,
    output logic en,
    output logic kill
);
    localparam int unsigned CW = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic       own;
    logic       clr;
    logic       ld;
    logic [1:0] sync_q;
    lane_sync_t ls;
    hs_state_e  state;
    logic [CW-1:0] wait_cnt;
    logic       go;

    assign own = sel_hits(sel, IDX);
    assign clr = rst | peer_kill;
    assign ld  = rst ? own : 1'b0;

    chs_sync2 #(.W(2)) u_sync (
        .clk  (lane_clk),
        .clr  (clr),
        .load ({ld, ld}),
        .d    ({own, ~peer_en}),
        .q    (sync_q)
    );

    assign ls = lane_sync_t'(sync_q);

    always_ff @(posedge lane_clk or posedge clr) begin
        if (clr) begin
            state    <= rst ? boot_state(own) : HS_IDLE;
            wait_cnt <= '0;
        end else begin
            case (state)
                HS_IDLE: begin
                    wait_cnt <= '0;
                    if (ls.req) state <= ls.peer_off ? HS_OWNED : HS_WAIT;
                end
                HS_WAIT: begin
                    if (!ls.req) begin
                        state <= HS_IDLE;
                    end else if (ls.peer_off) begin
                        state <= HS_OWNED;
                    end else if (wait_cnt == LAST) begin
                        state <= HS_FORCED;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                HS_OWNED, HS_FORCED: begin
                    if (!ls.req) state <= HS_IDLE;
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

    assign go   = ls.req & ls.peer_off & ((state == HS_OWNED) | (state == HS_FORCED));
    assign kill = (state == HS_FORCED);

    // Enable is moved only while the lane clock is low
    always_ff @(negedge lane_clk or posedge clr) begin
        if (clr) en <= ld;
        else     en <= go;
    end
endmodule

// File: rtl/chs_gate.sv
`timescale 1ns/100ps
module chs_gate #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] clk_v,
    input  logic [N-1:0] en_v,
    input  logic         sel,
    input  logic         bypass,
    output logic         clk_out
);
    logic gated;
    logic direct;

    assign gated   = |(clk_v & en_v);
    assign direct  = clk_v[sel];
    assign clk_out = bypass ? direct : gated;
endmodule

// File: rtl/clk_handover_mux.sv
`timescale 1ns/100ps
module clk_handover_mux
    import chs_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 12
) (
    input  logic clk0,
    input  logic clk1,
    input  logic rst,
    input  logic sel,
    input  logic bypass,
    output logic clk_out
);
    logic [N_LANES-1:0] clk_v;
    logic [N_LANES-1:0] lane_en;
    logic [N_LANES-1:0] lane_kill;

    assign clk_v = {clk1, clk0};

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        chs_lane #(
            .IDX         (g),
            .TIMEOUT_CYC (TIMEOUT_CYC)
        ) u_lane (
            .lane_clk  (clk_v[g]),
            .rst       (rst),
            .sel       (sel),
            .peer_en   (lane_en[N_LANES-1-g]),
            .peer_kill (lane_kill[N_LANES-1-g]),
            .en        (lane_en[g]),
            .kill      (lane_kill[g])
        );
    end

    chs_gate #(.N(N_LANES)) u_gate (
        .clk_v   (clk_v),
        .en_v    (lane_en),
        .sel     (sel),
        .bypass  (bypass),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/clk_handover_chk.sv
`timescale 1ns/100ps
module clk_handover_chk (
    input logic       clk0,
    input logic       clk1,
    input logic       rst,
    input logic [1:0] en,
    input logic [1:0] kill
);
    // R4: lanes never on together
    always_comb begin
        if (rst == 1'b0) begin
            a_r4_one_lane_on: assert (!(en[0] && en[1]))
                else $error("both lane enables high");
        end
    end

    // R4: enable rises only while own clock is low
    always @(posedge en[0]) begin
        if (rst == 1'b0) begin
            a_r4_rise_on_low0: assert (!clk0) else $error("lane0 enabled while clk0 high");
        end
    end

    always @(posedge en[1]) begin
        if (rst == 1'b0) begin
            a_r4_rise_on_low1: assert (!clk1) else $error("lane1 enabled while clk1 high");
        end
    end

    // R8: a forced release keeps the old lane off
    a_r8_kill_clears0: assert property (@(posedge clk1) disable iff (rst) kill[1] |=> !en[0])
        else $error("lane0 still enabled under force");

    a_r8_kill_clears1: assert property (@(posedge clk0) disable iff (rst) kill[0] |=> !en[1])
        else $error("lane1 still enabled under force");
endmodule

bind clk_handover_mux clk_handover_chk u_chk (
    .clk0 (clk0),
    .clk1 (clk1),
    .rst  (rst),
    .en   (lane_en),
    .kill (lane_kill)
);

// File: tb/clk_handover_mux_bench.sv
`timescale 1ns/100ps
module clk_handover_mux_bench;

    localparam int  P0 = 10;            // clk0 period, 100 MHz
    localparam int  P1 = 14;            // clk1 period, ratio 1.4
    localparam real MIN_PHASE = 5.0;    // half of the faster period

    logic clk0   = 1'b0;
    logic clk1   = 1'b0;
    logic rst    = 1'b1;
    logic sel    = 1'b0;
    logic bypass = 1'b0;
    logic clk_out;
    bit   run0 = 1'b1;
    bit   run1 = 1'b1;

    clk_handover_mux u_clk_handover_mux (
        .clk0    (clk0),
        .clk1    (clk1),
        .rst     (rst),
        .sel     (sel),
        .bypass  (bypass),
        .clk_out (clk_out)
    );

    always begin
        #(P0/2);
        if (run0) clk0 = ~clk0;
    end

    always begin
        #(P1/2);
        if (run1) clk1 = ~clk1;
    end

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
        end
    endtask

    task automatic follow(input bit src, input int n, output int mism);
        mism = 0;
        #0.5;
        for (int i = 0; i < n; i++) begin
            if (clk_out !== (src ? clk1 : clk0)) mism++;
            #1;
        end
        #0.5;
    endtask

    task automatic hold(input bit lvl, input int n, output int bad);
        bad = 0;
        #0.5;
        for (int i = 0; i < n; i++) begin
            if (clk_out !== lvl) bad++;
            #1;
        end
        #0.5;
    endtask

    // phase tracker
    bit  tracking  = 1'b0;
    bit  seen_edge = 1'b0;
    real last_edge = 0.0;
    real min_ph    = 1.0e9;

    always @(clk_out) begin
        if (tracking) begin
            if (seen_edge && ($realtime - last_edge) < min_ph) min_ph = $realtime - last_edge;
            seen_edge = 1'b1;
            last_edge = $realtime;
        end
    end

    // scoreboard
    typedef struct {
        bit    src;
        int    settle_ns;
        int    follow_ns;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   pushed = 0;
    int   done   = 0;

    task automatic switch_to(input bit s, input string tag);
        exp_t it;
        sel          = s;
        it.src       = s;
        it.settle_ns = 24 * (s ? P1 : P0);
        it.follow_ns = 200;
        it.tag       = tag;
        sb_q.push_back(it);
        pushed++;
    endtask

    task automatic wait_done();
        wait (done == pushed);
        #3;
    endtask

    initial begin
        forever begin
            exp_t it;
            int   mism;
            wait (pushed > done);
            it        = sb_q.pop_front();
            min_ph    = 1.0e9;
            seen_edge = 1'b0;
            tracking  = 1'b1;
            #(it.settle_ns);
            follow(it.src, it.follow_ns, mism);
            tracking = 1'b0;
            check(mism == 0, it.tag, "samples off the new clock", mism, 0);
            check(min_ph >= MIN_PHASE, "R3", "shortest output phase ns", min_ph, MIN_PHASE);
            done++;
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #200000;
        check(1'b0, "watchdog", "run did not complete", 0, 1);
        finish_run();
    end

    initial begin
        int bad;
        #33;
        rst = 1'b0;
        // R2: reset with sel low, clk0 on at once
        follow(1'b0, 100, bad);
        check(bad == 0, "R2", "post-reset samples off clk0", bad, 0);

        // live switches both ways
        switch_to(1'b1, "R1 R5 live to clk1");
        wait_done();
        switch_to(1'b0, "R1 R10 live to clk0");
        wait_done();

        // R6: clk0 dies high while selected
        @(posedge clk0);
        run0 = 1'b0;
        #20;
        check(clk_out === 1'b1, "R6", "output with clk0 stuck high", clk_out, 1);
        switch_to(1'b1, "R6 R8 follow clk1 after dead-high clk0");
        hold(1'b1, 8 * P1, bad);
        check(bad == 0, "R6", "samples not high in first 8 clk1 periods", bad, 0);
        wait_done();
        run0 = 1'b1;
        #40;

        switch_to(1'b0, "R1 R10 back to restarted clk0");
        wait_done();
        switch_to(1'b1, "R1 R5 live to clk1 again");
        wait_done();

        // R7: clk1 dies low while selected
        @(negedge clk1);
        run1 = 1'b0;
        #20;
        switch_to(1'b0, "R7 R10 follow clk0 after dead-low clk1");
        hold(1'b0, 8 * P0, bad);
        check(bad == 0, "R7", "samples not low in first 8 clk0 periods", bad, 0);
        wait_done();
        run1 = 1'b1;
        #40;

        // R10: dead-high on the other input
        switch_to(1'b1, "R1 live to clk1 before stall");
        wait_done();
        @(posedge clk1);
        run1 = 1'b0;
        #20;
        switch_to(1'b0, "R6 R10 follow clk0 after dead-high clk1");
        hold(1'b1, 8 * P0, bad);
        check(bad == 0, "R10", "samples not high in first 8 clk0 periods", bad, 0);
        wait_done();
        run1 = 1'b1;
        #40;

        // R2: reset with sel high
        sel = 1'b1;
        #2;
        rst = 1'b1;
        #30;
        rst = 1'b0;
        follow(1'b1, 100, bad);
        check(bad == 0, "R2", "post-reset samples off clk1", bad, 0);

        // R9: bypass switches at once
        bypass = 1'b1;
        #1;
        for (int k = 0; k < 4; k++) begin
            sel = ~sel;
            follow(sel, 30, bad);
            check(bad == 0, "R9", "bypass samples off selected clock", bad, 0);
        end

        finish_run();
    end
endmodule